// File: doc/BRIEF.md
# Registered-Bypass Output Macrocell

This block is one output cell of a programmable logic array in which every cell carries its own control terms. A shared input vector feeds a set of product terms, and each product term is configured by a pair of masks: one picks the inputs that must be high, the other picks the inputs that must be low. Up to four terms are ORed into the cell's data value. Four further single terms give the cell its own clock, asynchronous clear, asynchronous set and drive enable. Clock, clear and set therefore never depend on the neighbouring cells.

The storage element is emulated on a fast system clock. A rising edge of the cell's clock term is detected by sampling that term on the system clock. A clear or set term on its own overrides the stored bit at the pin at once, and the stored bit follows on the next system edge. When clear and set are both true, the flop is bypassed and the pin carries the combinational sum, so the cell can move between registered and combinational behaviour while it runs. The cell can also be configured as permanently combinational. A polarity bit inverts the pin value. A global active-low preload loads a given bit into the register, and a global active-low output enable gates the drive.

Top module: `regbyp_macrocell`

## Requirements
- R1: A product term is 1 when every input selected by its true mask is 1 and every input selected by its complement mask is 0. An all-zero mask pair gives 1, and a pair that selects both polarities of one input gives 0.
- R2: The data sum is the OR of the product terms whose use bit is set. With no use bit set, the sum is 0.
- R3: When the clock term is sampled 1 on a system edge after being sampled 0 on the previous one, and no clear, set or preload is active, the register takes the sum present at that edge.
- R4: While only the clear term is true, the register value seen at the pin is 0 in the same cycle, and the stored bit is 0 after the next system edge. This holds whatever the clock term does.
- R5: While only the set term is true, the register value seen at the pin is 1 in the same cycle, and the stored bit is 1 after the next system edge. This holds whatever the clock term does.
- R6: While the clear and set terms are both true, the pin carries the combinational sum and the stored bit is held unchanged.
- R7: A clear or set term whose use bit is 0 is inactive, whatever its masks select.
- R8: While preload_n is 0 and neither clear nor set is true, the register loads preload_bit on every system edge, whatever the clock term does.
- R9: With invert_out set to 1, the pin value is the complement of the selected register or sum value.
- R10: pin_oe is 1 only when oe_global_n is 0 and the enable term is true. While pin_oe is 0, pin_out is 0.
- R11: With comb_mode set to 1, the pin carries the sum (after polarity) and the clock term has no effect on it.
- R12: While rst_n is 0 the stored bit is 0 and the clock-term history is 0. A registered cell with no clear or set active therefore shows 0 (before polarity) after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low system reset |
| in_vec | input | N_IN | Shared product-term input vector |
| ck_true | input | N_IN | Clock term, true-literal mask |
| ck_comp | input | N_IN | Clock term, complement-literal mask |
| clr_true | input | N_IN | Clear term, true-literal mask |
| clr_comp | input | N_IN | Clear term, complement-literal mask |
| clr_used | input | 1 | Clear term defined |
| set_true | input | N_IN | Set term, true-literal mask |
| set_comp | input | N_IN | Set term, complement-literal mask |
| set_used | input | 1 | Set term defined |
| en_true | input | N_IN | Enable term, true-literal mask |
| en_comp | input | N_IN | Enable term, complement-literal mask |
| sum_true | input | N_TERMS*N_IN | Sum terms, true masks, term k in bits [k*N_IN +: N_IN] |
| sum_comp | input | N_TERMS*N_IN | Sum terms, complement masks, same layout |
| sum_used | input | N_TERMS | Sum term k takes part when bit k is 1 |
| comb_mode | input | 1 | 1 = cell is combinational |
| invert_out | input | 1 | 1 = pin value inverted |
| preload_n | input | 1 | Active-low global preload |
| preload_bit | input | 1 | Value loaded during preload |
| oe_global_n | input | 1 | Active-low global output enable |
| pin_out | output | 1 | Pin value (0 when not driven) |
| pin_oe | output | 1 | Pin drive enable |

## Verification
Clear and set meet in one cycle whenever both two-literal terms match the random input vector. That case must turn the cell into a bypass that holds its stored bit, and must not let either control win. Preload and the clock-term edge also meet, and so do each asynchronous control and a clock edge. The bench provokes all of these with sparse random masks and a random input vector on every cycle. A behavioural reference model judges the pin value and drive enable on every clock, and the register is allowed to move only on the edge that the model predicts.

// File: rtl/regbyp_pkg.sv
package regbyp_pkg;
  // What the storage element does on a system edge
  typedef enum logic [2:0] {
    ACT_HOLD    = 3'd0,
    ACT_CLEAR   = 3'd1,
    ACT_SET     = 3'd2,
    ACT_BYPASS  = 3'd3,
    ACT_PRELOAD = 3'd4,
    ACT_CAPTURE = 3'd5
  } reg_act_e;

  // Priority: async controls, then preload, then clock-term edge
  function automatic reg_act_e pick_action(input logic clr_t, input logic set_t,
                                           input logic pre_n, input logic edge_seen);
    if (clr_t && set_t)  return ACT_BYPASS;
    if (clr_t)           return ACT_CLEAR;
    if (set_t)           return ACT_SET;
    if (!pre_n)          return ACT_PRELOAD;
    if (edge_seen)       return ACT_CAPTURE;
    return ACT_HOLD;
  endfunction
endpackage

// File: rtl/mc_pterm.sv
module mc_pterm #(
  parameter int W = 8
) (
  input  logic [W-1:0] in_vec,
  input  logic [W-1:0] m_true,
  input  logic [W-1:0] m_comp,
  output logic         term
);
  // A literal fails when a true-selected input is low or a complement-selected input is high
  function automatic logic and_term(input logic [W-1:0] v, input logic [W-1:0] t,
                                    input logic [W-1:0] c);
    logic miss;
    logic clash;
    miss  = |(t & ~v) | |(c & v);
    clash = |(t & c);
    return !(miss || clash);
  endfunction

  assign term = and_term(in_vec, m_true, m_comp);
endmodule

// File: rtl/mc_sum.sv
module mc_sum #(
  parameter int W = 8,
  parameter int T = 4
) (
  input  logic [W-1:0]   in_vec,
  input  logic [T*W-1:0] m_true,
  input  logic [T*W-1:0] m_comp,
  input  logic [T-1:0]   used,
  output logic           sum
);
  logic [T-1:0] raw_terms;

  for (genvar k = 0; k < T; k++) begin : g_term
    mc_pterm #(.W(W)) u_pt (
      .in_vec (in_vec),
      .m_true (m_true[k*W +: W]),
      .m_comp (m_comp[k*W +: W]),
      .term   (raw_terms[k])
    );
  end

  assign sum = |(raw_terms & used);
endmodule

// File: rtl/mc_reg.sv
module mc_reg
  import regbyp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_t,
  input  logic set_t,
  input  logic preload_n,
  input  logic preload_bit,
  input  logic ck_edge,
  input  logic d,
  output logic q_state,
  output logic q_view
);
  reg_act_e act;
  logic     clr_only;
  logic     set_only;

  assign act      = pick_action(clr_t, set_t, preload_n, ck_edge);
  assign clr_only = clr_t & ~set_t;
  assign set_only = set_t & ~clr_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_state <= 1'b0;
    end else begin
      unique case (act)
        ACT_CLEAR:   q_state <= 1'b0;
        ACT_SET:     q_state <= 1'b1;
        ACT_PRELOAD: q_state <= preload_bit;
        ACT_CAPTURE: q_state <= d;
        default:     q_state <= q_state;
      endcase
    end
  end

  // Async override is visible at once, ahead of the stored bit
  assign q_view = clr_only ? 1'b0 : (set_only ? 1'b1 : q_state);

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_only |=> (q_state == 1'b0));
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_only |=> (q_state == 1'b1));
  p_bypass_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_t && set_t) |=> $stable(q_state));
  p_preload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_t && !set_t && !preload_n) |=> (q_state == $past(preload_bit)));
  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_t && !set_t && preload_n && ck_edge) |=> (q_state == $past(d)));
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_t && !set_t && preload_n && !ck_edge) |=> $stable(q_state));
endmodule

// File: rtl/regbyp_macrocell.sv
module regbyp_macrocell #(
  parameter int N_IN    = 8,
  parameter int N_TERMS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_IN-1:0]         in_vec,
  input  logic [N_IN-1:0]         ck_true,
  input  logic [N_IN-1:0]         ck_comp,
  input  logic [N_IN-1:0]         clr_true,
  input  logic [N_IN-1:0]         clr_comp,
  input  logic                    clr_used,
  input  logic [N_IN-1:0]         set_true,
  input  logic [N_IN-1:0]         set_comp,
  input  logic                    set_used,
  input  logic [N_IN-1:0]         en_true,
  input  logic [N_IN-1:0]         en_comp,
  input  logic [N_TERMS*N_IN-1:0] sum_true,
  input  logic [N_TERMS*N_IN-1:0] sum_comp,
  input  logic [N_TERMS-1:0]      sum_used,
  input  logic                    comb_mode,
  input  logic                    invert_out,
  input  logic                    preload_n,
  input  logic                    preload_bit,
  input  logic                    oe_global_n,
  output logic                    pin_out,
  output logic                    pin_oe
);
  localparam int SUM_W = N_TERMS * N_IN;

  logic ck_term, clr_raw, set_raw, en_term;
  logic clr_t, set_t;
  logic ck_prev, ck_edge;
  logic sum_val;
  logic q_state, q_view;
  logic bypass, cell_val;

  mc_pterm #(.W(N_IN)) u_ck  (.in_vec(in_vec), .m_true(ck_true),  .m_comp(ck_comp),  .term(ck_term));
  mc_pterm #(.W(N_IN)) u_clr (.in_vec(in_vec), .m_true(clr_true), .m_comp(clr_comp), .term(clr_raw));
  mc_pterm #(.W(N_IN)) u_set (.in_vec(in_vec), .m_true(set_true), .m_comp(set_comp), .term(set_raw));
  mc_pterm #(.W(N_IN)) u_en  (.in_vec(in_vec), .m_true(en_true),  .m_comp(en_comp),  .term(en_term));

  mc_sum #(.W(N_IN), .T(N_TERMS)) u_sum (
    .in_vec (in_vec),
    .m_true (sum_true[SUM_W-1:0]),
    .m_comp (sum_comp[SUM_W-1:0]),
    .used   (sum_used),
    .sum    (sum_val)
  );

  // Undefined controls stay inactive
  assign clr_t = clr_used & clr_raw;
  assign set_t = set_used & set_raw;

  // Rising edge of the cell's own clock term, seen on the system clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_prev <= 1'b0;
    else        ck_prev <= ck_term;
  end
  assign ck_edge = ck_term & ~ck_prev;

  mc_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_t       (clr_t),
    .set_t       (set_t),
    .preload_n   (preload_n),
    .preload_bit (preload_bit),
    .ck_edge     (ck_edge),
    .d           (sum_val),
    .q_state     (q_state),
    .q_view      (q_view)
  );

  assign bypass   = comb_mode | (clr_t & set_t);
  assign cell_val = (bypass ? sum_val : q_view) ^ invert_out;
  assign pin_oe   = ~oe_global_n & en_term;
  assign pin_out  = pin_oe & cell_val;

  p_global_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    oe_global_n |-> !pin_oe);
  p_quiet_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);
  p_bypass_pin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_t && set_t && pin_oe) |-> (pin_out == (sum_val ^ invert_out)));
  p_comb_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (comb_mode && pin_oe) |-> (pin_out == (sum_val ^ invert_out)));
  p_unused_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_used && !set_used) |-> (!clr_t && !set_t));
endmodule

// File: tb/regbyp_macrocell_test.sv
module regbyp_macrocell_test;
  localparam int W = 8;
  localparam int T = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0]   in_vec, ck_t, ck_c, cl_t, cl_c, st_t, st_c, en_t, en_c;
  logic [T*W-1:0] sm_t, sm_c;
  logic [T-1:0]   sm_u;
  logic cl_u, st_u, comb, inv, pl_n, pl_d, goe_n;
  wire  pin_out, pin_oe;

  regbyp_macrocell #(.N_IN(W), .N_TERMS(T)) uut (
    .clk(clk), .rst_n(rst_n), .in_vec(in_vec),
    .ck_true(ck_t), .ck_comp(ck_c),
    .clr_true(cl_t), .clr_comp(cl_c), .clr_used(cl_u),
    .set_true(st_t), .set_comp(st_c), .set_used(st_u),
    .en_true(en_t), .en_comp(en_c),
    .sum_true(sm_t), .sum_comp(sm_c), .sum_used(sm_u),
    .comb_mode(comb), .invert_out(inv),
    .preload_n(pl_n), .preload_bit(pl_d), .oe_global_n(goe_n),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  int compared = 0;
  int mismatched = 0;
  bit pl_rand = 0;
  bit goe_rand = 0;

  // Reference model state
  bit m_q = 0;
  bit m_ckprev = 0;

  function automatic bit lit_ok(input logic [W-1:0] v, input logic [W-1:0] t,
                                input logic [W-1:0] c);
    bit r = 1;
    for (int i = 0; i < W; i++) begin
      if (t[i] && !v[i]) r = 0;
      if (c[i] && v[i])  r = 0;
    end
    return r;
  endfunction

  function automatic bit model_sum(input logic [W-1:0] v);
    bit r = 0;
    for (int k = 0; k < T; k++)
      if (sm_u[k] && lit_ok(v, sm_t[k*W +: W], sm_c[k*W +: W])) r = 1;
    return r;
  endfunction

  always @(posedge clk) begin
    bit ck, c, s;
    if (!rst_n) begin
      m_q = 0;
      m_ckprev = 0;
    end else begin
      ck = lit_ok(in_vec, ck_t, ck_c);
      c  = cl_u && lit_ok(in_vec, cl_t, cl_c);
      s  = st_u && lit_ok(in_vec, st_t, st_c);
      if (c && !s)          m_q = 0;
      else if (s && !c)     m_q = 1;
      else if (c && s)      m_q = m_q;
      else if (!pl_n)       m_q = pl_d;
      else if (ck && !m_ckprev) m_q = model_sum(in_vec);
      m_ckprev = ck;
    end
  end

  task automatic check_pin(input string tag);
    bit c, s, v, oe, o;
    c = cl_u && lit_ok(in_vec, cl_t, cl_c);
    s = st_u && lit_ok(in_vec, st_t, st_c);
    if (comb || (c && s)) v = model_sum(in_vec);
    else if (c)           v = 0;
    else if (s)           v = 1;
    else                  v = m_q;
    v  = v ^ inv;
    oe = !goe_n && lit_ok(in_vec, en_t, en_c);
    o  = oe ? v : 1'b0;
    compared++;
    if (pin_out !== o || pin_oe !== oe) begin
      mismatched++;
      $display("FAIL %s t=%0t: pin_out=%b pin_oe=%b expected pin_out=%b pin_oe=%b",
               tag, $time, pin_out, pin_oe, o, oe);
    end
  endtask

  function automatic logic [W-1:0] sparse();
    return W'($urandom & $urandom & $urandom);
  endfunction

  function automatic logic [W-1:0] one_hot_bit();
    return W'(1) << ($urandom % W);
  endfunction

  task automatic base_config();
    ck_t = one_hot_bit(); ck_c = '0;
    cl_t = '0; cl_c = '0; cl_u = 0;
    st_t = '0; st_c = '0; st_u = 0;
    en_t = '0; en_c = '0;
    for (int k = 0; k < T; k++) begin
      sm_t[k*W +: W] = sparse();
      sm_c[k*W +: W] = sparse() & ~sm_t[k*W +: W];
    end
    sm_u = T'($urandom);
    comb = 0; inv = 0; pl_n = 1; pl_d = 0; goe_n = 0;
    pl_rand = 0; goe_rand = 0;
  endtask

  task automatic two_lit(output logic [W-1:0] t, output logic [W-1:0] c);
    int a = $urandom % W;
    int b = (a + 1 + ($urandom % (W - 1))) % W;
    t = '0; c = '0;
    t[a] = 1'b1;
    if ($urandom % 2) t[b] = 1'b1; else c[b] = 1'b1;
  endtask

  task automatic run_phase(input string tag, input int n);
    repeat (n) begin
      @(negedge clk);
      check_pin(tag);
      in_vec = W'($urandom);
      pl_d   = 1'($urandom);
      if (pl_rand)  pl_n  = ($urandom % 5) != 0;
      if (goe_rand) goe_n = ($urandom % 4) == 0;
    end
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog expired (all requirements)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    base_config();
    sm_u = '0;
    in_vec = '0;
    repeat (3) @(negedge clk);
    // R12: held in reset, registered cell shows 0
    check_pin("R12 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_pin("R12 after reset");
    compared++;
    if (pin_out !== 1'b0) begin
      mismatched++;
      $display("FAIL R12: pin_out=%b expected 0", pin_out);
    end

    // R1 directed: all-zero masks give 1 (enable term), clashing pair gives 0
    sm_t = '0; sm_c = '0; sm_u = '0;
    sm_t[0] = 1'b1; sm_c[0] = 1'b1; sm_u[0] = 1'b1;
    comb = 1;
    for (int v = 0; v < 2; v++) begin
      in_vec = W'(v);
      @(negedge clk);
      compared++;
      if (pin_oe !== 1'b1 || pin_out !== 1'b0) begin
        mismatched++;
        $display("FAIL R1 clash/empty: pin_out=%b pin_oe=%b expected 0/1", pin_out, pin_oe);
      end
    end
    // R2: no used terms gives 0 even with a matching term
    sm_t = '0; sm_c = '0; sm_u = '0;
    @(negedge clk);
    compared++;
    if (pin_out !== 1'b0) begin
      mismatched++;
      $display("FAIL R2 no terms used: pin_out=%b expected 0", pin_out);
    end

    for (int rep = 0; rep < 3; rep++) begin
      base_config();
      run_phase("R1 R2 R3", 300);

      base_config();
      two_lit(cl_t, cl_c); two_lit(st_t, st_c); cl_u = 1; st_u = 1;
      run_phase("R4 R5 R6", 300);

      base_config();
      two_lit(cl_t, cl_c); two_lit(st_t, st_c);
      cl_u = 0; st_u = 0;
      run_phase("R7", 150);

      base_config();
      two_lit(cl_t, cl_c); cl_u = 1;
      pl_rand = 1;
      run_phase("R8", 300);

      base_config();
      two_lit(st_t, st_c); st_u = 1; inv = 1;
      run_phase("R9", 200);

      base_config();
      en_t = sparse(); en_c = sparse() & ~en_t; goe_rand = 1;
      run_phase("R10", 250);

      base_config();
      comb = 1; inv = 1'($urandom);
      run_phase("R11", 200);

      base_config();
      sm_c[W +: W] = sm_c[W +: W] | sm_t[W +: W] | W'(1);
      sm_t[W +: W] = sm_t[W +: W] | W'(1);
      sm_u[1] = 1'b1;
      run_phase("R1 clash", 150);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule